// File: doc/BRIEF.md
# Memory Error-Check Policy Unit

This block sits beside the checkers of several memory banks and decides what an error on an access means for the system. Each cycle it receives parity error strobes from a set of parity-protected banks and from a cache RAM, and single-bit and double-bit error strobes from two ECC-protected banks. It turns these strobes into sticky status flags. Depending on configuration, it also raises either a non-maskable interrupt level or a one-cycle system reset request.

Software configures the unit through a small write port with three targets: a key register, a control register and a flag-clear register. The control register changes only while the key register holds the unlock value. It holds a two-bit ECC mode per ECC bank and three action selects: one for the parity group and one for each ECC bank. The flags are cleared by writing ones to the clear target. The current control value and flags are brought out as ports.

Top module: `mem_err_policy`

## Requirements
- R1: After reset, `ctrl_q`, `flags_q`, `nmi` and `rst_req` are all zero and the key register does not hold the unlock value.
- R2: A write with `reg_sel`=0 loads `reg_wdata[15:0]` into the key register. A write with `reg_sel`=1 loads `reg_wdata[6:0]` into `ctrl_q` only if the key register holds 16'h3C5A; otherwise `ctrl_q` is unchanged. Control layout: ECC bank k mode at bits [2k+1:2k] (bank 1 two bits above bank 0), parity-group action at bit 4, ECC bank k action at bit 5+k.
- R3: A parity strobe always sets its flag, visible on the clock edge that samples it. Bank parity flags are `flags_q[3:0]` and the cache flag is `flags_q[4]`. Every parity event escalates through the parity-group action.
- R4: In ECC mode 0, both error strobes of that bank are ignored: no flag, no NMI, no reset request.
- R5: In ECC mode 1, a single-bit strobe sets no flag and causes no escalation. A double-bit strobe sets the bank's double-bit flag (`flags_q[6+2k]`) and escalates.
- R6: In ECC mode 2, a single-bit strobe sets the bank's single-bit flag (`flags_q[5+2k]`) but does not escalate.
- R7: In ECC mode 3, a single-bit strobe sets its flag and escalates.
- R8: Each of the three action selects is independent: a value of 0 routes that group's escalation to `nmi`, and 1 routes it to `rst_req`.
- R9: `nmi` is high while any set flag both escalates under the current mode and has its group's action at 0. It falls once those flags are cleared.
- R10: `rst_req` goes high for one cycle, in the cycle after each cycle that carries a reset-routed escalating event.
- R11: A write with `reg_sel`=2 clears every flag whose `reg_wdata` bit is 1 and leaves the other flags alone. If an event and a clear hit the same flag in the same cycle, the flag stays set.
- R12: De-initialisation, done by writing control 0 while unlocked and then clearing with all ones, returns `ctrl_q` and `flags_q` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 key, 1 control, 2 flag clear |
| reg_wdata | input | 32 | Write data |
| par_err | input | 4 | Parity error strobes, one per parity bank |
| cache_par_err | input | 1 | Cache RAM parity error strobe |
| ecc_sb_err | input | 2 | Single-bit ECC error strobes, one per ECC bank |
| ecc_db_err | input | 2 | Double-bit ECC error strobes, one per ECC bank |
| ctrl_q | output | 7 | Current control register |
| flags_q | output | 9 | Sticky error flags |
| nmi | output | 1 | Non-maskable interrupt level |
| rst_req | output | 1 | System reset request pulse |

## Verification
Register writes and error strobes are sampled on one rising edge. `ctrl_q` and `flags_q` show the result right after that edge. `nmi` follows the flags and control with no extra register, so it is due at the same point. `rst_req` comes from one register fed by that same edge, so it is visible in that cycle and must be low one cycle later. The bench drives every stimulus on a falling edge and removes it at the next falling edge, where it samples all outputs. It then checks `rst_req` again one falling edge later to confirm that the pulse has ended.

// File: rtl/mep_pkg.sv
package mep_pkg;
   typedef enum logic [1:0] {
      SEL_KEY  = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_CLR  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      ECC_OFF   = 2'd0,
      ECC_QUIET = 2'd1,
      ECC_FLAG  = 2'd2,
      ECC_ESC   = 2'd3
   } ecc_mode_e;
endpackage

// File: rtl/mep_ctrl.sv
module mep_ctrl
   import mep_pkg::*;
#(
   parameter int DW         = 32,
   parameter int KEY_W      = 16,
   parameter int CTRL_W     = 7,
   parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'h3C5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [1:0]        sel,
   input  logic [DW-1:0]     wdata,
   output logic [CTRL_W-1:0] ctrl_q
);
   logic [KEY_W-1:0] key_q;
   logic             unlocked;

   if (KEY_W > DW || CTRL_W > DW) begin : g_bad_width
      $error("mep_ctrl: key or control wider than write data");
   end

   assign unlocked = (key_q == UNLOCK_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q  <= '0;
         ctrl_q <= '0;
      end else if (wr) begin
         if (sel == SEL_KEY) key_q <= wdata[KEY_W-1:0];
         if (sel == SEL_CTRL && unlocked) ctrl_q <= wdata[CTRL_W-1:0];
      end
   end

   p_locked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_CTRL && key_q != UNLOCK_KEY) |=> $stable(ctrl_q));
   p_no_write_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr) |=> $stable(ctrl_q));
endmodule

// File: rtl/mep_ecc_qual.sv
module mep_ecc_qual
   import mep_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       sb_err,
   input  logic       db_err,
   output logic       set_sb,
   output logic       set_db,
   output logic       cap_sb,
   output logic       cap_db
);
   ecc_mode_e m;
   assign m = ecc_mode_e'(mode);

   always_comb begin
      set_sb = 1'b0;
      set_db = 1'b0;
      cap_sb = 1'b0;
      cap_db = 1'b0;
      unique case (m)
         ECC_OFF: ;
         ECC_QUIET: begin
            set_db = db_err;
            cap_db = 1'b1;
         end
         ECC_FLAG: begin
            set_sb = sb_err;
            set_db = db_err;
            cap_db = 1'b1;
         end
         ECC_ESC: begin
            set_sb = sb_err;
            set_db = db_err;
            cap_sb = 1'b1;
            cap_db = 1'b1;
         end
         default: ;
      endcase
   end

   p_off_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0) |-> (!set_sb && !set_db && !cap_sb && !cap_db));
   p_quiet_sb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1) |-> (!set_sb && !cap_sb));
   p_flag_no_esc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && sb_err) |-> (set_sb && !cap_sb));
endmodule

// File: rtl/mep_status.sv
module mep_status #(
   parameter int NF = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set,
   input  logic          clr_en,
   input  logic [NF-1:0] clr_mask,
   output logic [NF-1:0] flags_q
);
   logic [NF-1:0] clr_bits;
   assign clr_bits = clr_en ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_bits) | set;
   end

   for (genvar i = 0; i < NF; i++) begin : g_chk
      p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags_q[i]);
      p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_q[i] && !clr_bits[i]) |=> flags_q[i]);
   end
endmodule

// File: rtl/mem_err_policy.sv
module mem_err_policy
   import mep_pkg::*;
#(
   parameter int NUM_PAR = 4,
   parameter int NUM_ECC = 2,
   parameter int DW      = 32,
   parameter int KEY_W   = 16,
   parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'h3C5A
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [1:0]           reg_sel,
   input  logic [DW-1:0]        reg_wdata,
   input  logic [NUM_PAR-1:0]   par_err,
   input  logic                 cache_par_err,
   input  logic [NUM_ECC-1:0]   ecc_sb_err,
   input  logic [NUM_ECC-1:0]   ecc_db_err,
   output logic [3*NUM_ECC:0]   ctrl_q,
   output logic [NUM_PAR+2*NUM_ECC:0] flags_q,
   output logic                 nmi,
   output logic                 rst_req
);
   localparam int CTRL_W  = 3*NUM_ECC + 1;
   localparam int NF      = NUM_PAR + 1 + 2*NUM_ECC;
   localparam int PAR_ACT = 2*NUM_ECC;
   localparam int ECC_ACT = 2*NUM_ECC + 1;
   localparam int ECC_F0  = NUM_PAR + 1;

   if (NUM_PAR < 1 || NUM_ECC < 1) begin : g_bad_cfg
      $error("mem_err_policy: need at least one parity and one ECC bank");
   end
   if (NF > DW) begin : g_bad_dw
      $error("mem_err_policy: flag count exceeds write data width");
   end

   logic [NF-1:0] set_vec;
   logic [NF-1:0] cap_vec;
   logic [NF-1:0] act_vec;
   logic          clr_en;

   mep_ctrl #(
      .DW(DW), .KEY_W(KEY_W), .CTRL_W(CTRL_W), .UNLOCK_KEY(UNLOCK_KEY)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
      .wdata(reg_wdata), .ctrl_q(ctrl_q)
   );

   assign set_vec[NUM_PAR-1:0] = par_err;
   assign set_vec[NUM_PAR]     = cache_par_err;
   assign cap_vec[NUM_PAR:0]   = '1;
   assign act_vec[NUM_PAR:0]   = {(NUM_PAR+1){ctrl_q[PAR_ACT]}};

   for (genvar k = 0; k < NUM_ECC; k++) begin : g_ecc
      mep_ecc_qual u_qual (
         .clk(clk), .rst_n(rst_n),
         .mode(ctrl_q[2*k+1:2*k]),
         .sb_err(ecc_sb_err[k]),
         .db_err(ecc_db_err[k]),
         .set_sb(set_vec[ECC_F0+2*k]),
         .set_db(set_vec[ECC_F0+2*k+1]),
         .cap_sb(cap_vec[ECC_F0+2*k]),
         .cap_db(cap_vec[ECC_F0+2*k+1])
      );
      assign act_vec[ECC_F0+2*k]   = ctrl_q[ECC_ACT+k];
      assign act_vec[ECC_F0+2*k+1] = ctrl_q[ECC_ACT+k];
   end

   assign clr_en = reg_wr && (reg_sel == SEL_CLR);

   mep_status #(.NF(NF)) u_status (
      .clk(clk), .rst_n(rst_n), .set(set_vec), .clr_en(clr_en),
      .clr_mask(reg_wdata[NF-1:0]), .flags_q(flags_q)
   );

   assign nmi = |(flags_q & cap_vec & ~act_vec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req <= 1'b0;
      else        rst_req <= |(set_vec & cap_vec & act_vec);
   end

   p_nmi_has_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |-> (flags_q != '0));
   p_rst_from_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(set_vec != '0));
   p_rst_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (flags_q != '0));
endmodule

// File: tb/mem_err_policy_bench.sv
module mem_err_policy_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd3;
   logic [31:0] reg_wdata = '0;
   logic [3:0]  par_err = '0;
   logic        cache_par_err = 1'b0;
   logic [1:0]  ecc_sb_err = '0;
   logic [1:0]  ecc_db_err = '0;
   logic [6:0]  ctrl_q;
   logic [8:0]  flags_q;
   logic        nmi;
   logic        rst_req;

   int checks = 0;
   int bad = 0;

   always #5 clk = ~clk;

   mem_err_policy u_mem_err_policy (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .par_err(par_err), .cache_par_err(cache_par_err),
      .ecc_sb_err(ecc_sb_err), .ecc_db_err(ecc_db_err), .ctrl_q(ctrl_q),
      .flags_q(flags_q), .nmi(nmi), .rst_req(rst_req)
   );

   task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", what, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
   endtask

   task automatic set_ctrl(input logic [6:0] v);
      wr(2'd0, 32'h3C5A);
      wr(2'd1, {25'd0, v});
   endtask

   task automatic clear_all();
      wr(2'd2, 32'h1FF);
   endtask

   task automatic inject(input logic [3:0] p, input logic c, input logic [1:0] sb, input logic [1:0] db);
      @(negedge clk);
      par_err = p; cache_par_err = c; ecc_sb_err = sb; ecc_db_err = db;
      @(negedge clk);
      par_err = '0; cache_par_err = 1'b0; ecc_sb_err = '0; ecc_db_err = '0;
   endtask

   task automatic t_reset();
      chk("R1 ctrl", ctrl_q, 0);
      chk("R1 flags", flags_q, 0);
      chk("R1 nmi", nmi, 0);
      chk("R1 rst_req", rst_req, 0);
   endtask

   task automatic t_lock();
      wr(2'd1, 32'h7F);
      chk("R2 locked write ignored", ctrl_q, 0);
      wr(2'd0, 32'h1234);
      wr(2'd1, 32'h7F);
      chk("R2 wrong key ignored", ctrl_q, 0);
      set_ctrl(7'h15);
      chk("R2 unlocked write", ctrl_q, 7'h15);
      wr(2'd0, 32'h0);
      wr(2'd1, 32'h0);
      chk("R2 relocked write ignored", ctrl_q, 7'h15);
   endtask

   task automatic t_parity_nmi();
      set_ctrl(7'h00);
      inject(4'b0101, 1'b0, 2'b00, 2'b00);
      chk("R3 parity flags", flags_q, 9'h005);
      chk("R9 parity nmi", nmi, 1);
      chk("R8 parity no reset", rst_req, 0);
      inject(4'b0000, 1'b1, 2'b00, 2'b00);
      chk("R3 cache flag", flags_q, 9'h015);
      clear_all();
      chk("R9 nmi falls after clear", nmi, 0);
      chk("R11 all cleared", flags_q, 0);
   endtask

   task automatic t_parity_reset();
      set_ctrl(7'h10);
      inject(4'b0010, 1'b0, 2'b00, 2'b00);
      chk("R3 parity flag reset group", flags_q, 9'h002);
      chk("R10 reset pulse", rst_req, 1);
      chk("R8 parity reset no nmi", nmi, 0);
      @(negedge clk);
      chk("R10 pulse one cycle", rst_req, 0);
      clear_all();
   endtask

   task automatic t_mode0();
      set_ctrl(7'h70);
      inject(4'b0000, 1'b0, 2'b11, 2'b11);
      chk("R4 mode0 no flags", flags_q, 0);
      chk("R4 mode0 no reset", rst_req, 0);
      chk("R4 mode0 no nmi", nmi, 0);
   endtask

   task automatic t_mode1();
      set_ctrl(7'h01);
      inject(4'b0000, 1'b0, 2'b01, 2'b00);
      chk("R5 mode1 sb no flag", flags_q, 0);
      chk("R5 mode1 sb no nmi", nmi, 0);
      inject(4'b0000, 1'b0, 2'b00, 2'b01);
      chk("R5 mode1 db flag", flags_q, 9'h040);
      chk("R5 mode1 db nmi", nmi, 1);
      clear_all();
   endtask

   task automatic t_mode2();
      set_ctrl(7'h48);
      inject(4'b0000, 1'b0, 2'b10, 2'b00);
      chk("R6 mode2 sb flag", flags_q, 9'h080);
      chk("R6 mode2 sb no reset", rst_req, 0);
      chk("R6 mode2 sb no nmi", nmi, 0);
      inject(4'b0000, 1'b0, 2'b00, 2'b10);
      chk("R5 mode2 db flag", flags_q, 9'h180);
      chk("R10 mode2 db reset", rst_req, 1);
      clear_all();
   endtask

   task automatic t_mode3();
      set_ctrl(7'h23);
      inject(4'b0000, 1'b0, 2'b01, 2'b00);
      chk("R7 mode3 sb flag", flags_q, 9'h020);
      chk("R7 mode3 sb reset", rst_req, 1);
      chk("R7 mode3 no nmi", nmi, 0);
      clear_all();
   endtask

   task automatic t_independent();
      set_ctrl(7'h2F);
      inject(4'b0000, 1'b0, 2'b00, 2'b11);
      chk("R8 both db flags", flags_q, 9'h140);
      chk("R8 bank0 reset", rst_req, 1);
      chk("R8 bank1 nmi", nmi, 1);
      wr(2'd2, 32'h040);
      chk("R11 partial clear", flags_q, 9'h100);
      chk("R9 nmi held by bank1", nmi, 1);
      clear_all();
   endtask

   task automatic t_same_cycle();
      set_ctrl(7'h10);
      inject(4'b0011, 1'b0, 2'b00, 2'b00);
      chk("R11 setup", flags_q, 9'h003);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h003; par_err = 4'b0001;
      @(negedge clk);
      reg_wr = 1'b0; reg_sel = 2'd3; reg_wdata = '0; par_err = '0;
      chk("R11 event beats clear", flags_q, 9'h001);
   endtask

   task automatic t_deinit();
      set_ctrl(7'h00);
      clear_all();
      chk("R12 ctrl zero", ctrl_q, 0);
      chk("R12 flags zero", flags_q, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lock();
      t_parity_nmi();
      t_parity_reset();
      t_mode0();
      t_mode1();
      t_mode2();
      t_mode3();
      t_independent();
      t_same_cycle();
      t_deinit();
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule